// File: doc/BRIEF.md
# Glitch-Free Clock Selector with Monitor

This block produces the system clock from one of four oscillator inputs and divides the chosen clock by a programmable power of two. Source code 0 is the RF crystal oscillator, 1 is the low-frequency crystal oscillator, 2 is the internal 20 MHz RC oscillator and 3 is the internal low-power oscillator. A change of source or divider never lets a runt pulse reach the output. Each source sits behind its own gate. The old gate is closed, the new source's ready input is awaited, and then the new gate is opened. Every gate opens and closes on its own clock's falling edge, after a two-flop synchronizer in that clock's domain.

A control register holds the wanted source and divide exponent. A `busy` output stays high while a switch runs. The sequencing runs on `ref_clk`, an always-running reference clock. A clock monitor on that reference watches the output clock. If the output shows no edge for `tmo_limit` reference cycles while no switch is running, the monitor returns the control register to its reset value. The reset value is the RC oscillator divided by two, so the block falls back to that clock.

The sequencer has four states:
- ST_IDLE is the settled state. From it, a differing control register leads to ST_DROP, and a monitor timeout leads to ST_WAKE.
- ST_DROP lowers the old gate's request and waits for that gate to acknowledge the close. It then copies the control register into the active selection and moves to ST_WAKE.
- ST_WAKE waits for the new source's ready input, raises that source's request and moves to ST_RAISE.
- ST_RAISE waits for the new gate to acknowledge the open and returns to ST_IDLE.

Reset enters ST_RAISE with the RC source requested.

Top module: `clk_selector`

## Requirements
- R1: While reset is asserted and after it, `ctl_src` reads 2 and `ctl_div` reads 1 until the first write. Once `busy` falls after reset, the output period is twice the RC source period.
- R2: After a switch completes, the `sys_clk` period equals the period of source `ctl_src` times 2 to the power `ctl_div`, for every source code 0 to 3 and every divide exponent.
- R3: From the write that starts a switch until the switched clock is measured, no high or low phase of `sys_clk` is shorter than the shortest half period of any source.
- R4: A write on a rising `ref_clk` edge k whose value differs from the active selection raises `busy` right after edge k+1. `busy` then falls once the new clock runs, within a bound set by the old and new source periods.
- R5: A write made while `busy` is high is held in the control register and read back at once. After the running switch, the last value written is the one applied.
- R6: A write equal to the active selection starts no switch, and `busy` stays low.
- R7: While the new source's ready input is low, `busy` stays high and `sys_clk` shows no edges. The switch completes after ready rises.
- R8: While idle, if `sys_clk` has no edge for `tmo_limit` reference cycles, `ctl_src` becomes 2 and `ctl_div` becomes 1. The output then resumes at the RC source divided by two.
- R9: A `tmo_limit` of 0 disables the monitor, so a stopped output leaves the control register unchanged.
- R10: The monitor does not count while a switch is in progress, so a long wait for ready never triggers a fallback.
- R11: A write that changes only the divider also passes through the full switch sequence and yields the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Always-running reference clock for control, sequencing and the monitor |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | 4 | Oscillator inputs, indexed by source code |
| src_ready | input | 4 | Per-source ready flags, indexed by source code |
| wr_en | input | 1 | Control register write strobe (ref_clk domain) |
| wr_src | input | 2 | Source code to write |
| wr_div | input | DIV_W (3) | Divide exponent to write |
| tmo_limit | input | TMO_W (16) | Monitor timeout in ref_clk cycles, 0 disables |
| sys_clk | output | 1 | Selected and divided system clock |
| busy | output | 1 | High while a switch is in progress |
| ctl_src | output | 2 | Control register source field |
| ctl_div | output | DIV_W (3) | Control register divide field |

## Verification
The control register reads back one `ref_clk` edge after a write, and `busy` rises one edge after that. The bench therefore drives each write on a falling reference edge and checks `busy` at the second falling edge that follows. Switch completion depends on asynchronous synchronizers in four clock domains, so the bench waits for `busy` to fall within a bounded number of reference cycles. It then discards two output edges and takes the period from the third. The fallback happens about `tmo_limit` plus three reference cycles after the output stops. The bench samples the control register well after that point, and well inside the window when testing the disabled and busy cases.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
    localparam int NSRC  = 4;
    localparam int SRC_W = $clog2(NSRC);

    localparam logic [SRC_W-1:0] SRC_RF = 2'd0;
    localparam logic [SRC_W-1:0] SRC_LF = 2'd1;
    localparam logic [SRC_W-1:0] SRC_RC = 2'd2;
    localparam logic [SRC_W-1:0] SRC_LP = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DROP,
        ST_WAKE,
        ST_RAISE
    } sw_state_t;
endpackage

// File: rtl/clksel_sync.sv
module clksel_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= 1'b0;
            q      <= 1'b0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/clksel_gate.sv
module clksel_gate (
    input  logic src_clk,
    input  logic rst_n,
    input  logic req,
    output logic gclk,
    output logic en
);
    logic req_s;

    clksel_sync u_req_sync (
        .clk   (src_clk),
        .rst_n (rst_n),
        .d     (req),
        .q     (req_s)
    );

    // Enable changes only while the source is low.
    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) en <= 1'b0;
        else        en <= req_s;
    end

    assign gclk = src_clk & en;
endmodule

// File: rtl/clksel_prescale.sv
module clksel_prescale #(
    parameter int DIV_W = 3
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             clk_out
);
    localparam int NTAP  = 1 << DIV_W;
    localparam int CNT_W = NTAP - 1;

    logic [CNT_W-1:0] cnt;
    logic [NTAP-1:0]  taps;

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // Tap k has a period of 2**k input periods; div only changes while clk_in is gated off.
    assign taps    = {cnt, clk_in};
    assign clk_out = taps[div];
endmodule

// File: rtl/clksel_monitor.sv
module clksel_monitor #(
    parameter int TMO_W = 16
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             sys_clk,
    input  logic             arm,
    input  logic [TMO_W-1:0] limit,
    output logic             fault
);
    logic tgl;
    logic tgl_s;
    logic tgl_prev;
    logic edge_seen;
    logic [TMO_W-1:0] quiet_cnt;

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) tgl <= 1'b0;
        else        tgl <= ~tgl;
    end

    clksel_sync u_tgl_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (tgl),
        .q     (tgl_s)
    );

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) tgl_prev <= 1'b0;
        else        tgl_prev <= tgl_s;
    end

    assign edge_seen = tgl_s ^ tgl_prev;
    assign fault     = arm && (limit != '0) && (quiet_cnt >= limit);

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n)                         quiet_cnt <= '0;
        else if (!arm || edge_seen || fault) quiet_cnt <= '0;
        else if (quiet_cnt != '1)           quiet_cnt <= quiet_cnt + 1'b1;
    end
endmodule

// File: rtl/clk_selector.sv
module clk_selector
    import clksel_pkg::*;
#(
    parameter int DIV_W   = 3,
    parameter int TMO_W   = 16,
    parameter int DEF_DIV = 1
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_clk,
    input  logic [NSRC-1:0]  src_ready,
    input  logic             wr_en,
    input  logic [SRC_W-1:0] wr_src,
    input  logic [DIV_W-1:0] wr_div,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic             sys_clk,
    output logic             busy,
    output logic [SRC_W-1:0] ctl_src,
    output logic [DIV_W-1:0] ctl_div
);
    localparam logic [DIV_W-1:0] DIV_RST   = DIV_W'(DEF_DIV);
    localparam logic [NSRC-1:0]  RC_ONEHOT = NSRC'(1) << SRC_RC;

    sw_state_t        state_q, state_d;
    logic [SRC_W-1:0] ctl_src_q, act_src;
    logic [DIV_W-1:0] ctl_div_q, act_div;
    logic [NSRC-1:0]  req_q, gate_en, ack_s, gclk;
    logic             mux_clk, mon_fault, cfg_diff;

    // Per-source gate plus acknowledge synchronizer back to the reference domain
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        clksel_gate u_gate (
            .src_clk (src_clk[i]),
            .rst_n   (rst_n),
            .req     (req_q[i]),
            .gclk    (gclk[i]),
            .en      (gate_en[i])
        );
        clksel_sync u_ack (
            .clk   (ref_clk),
            .rst_n (rst_n),
            .d     (gate_en[i]),
            .q     (ack_s[i])
        );
    end

    assign mux_clk = |gclk;

    clksel_prescale #(.DIV_W(DIV_W)) u_prescale (
        .clk_in  (mux_clk),
        .rst_n   (rst_n),
        .div     (act_div),
        .clk_out (sys_clk)
    );

    clksel_monitor #(.TMO_W(TMO_W)) u_monitor (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .sys_clk (sys_clk),
        .arm     (state_q == ST_IDLE),
        .limit   (tmo_limit),
        .fault   (mon_fault)
    );

    // Control register: a timeout overrides a write in the same cycle
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_src_q <= SRC_RC;
            ctl_div_q <= DIV_RST;
        end else if (mon_fault) begin
            ctl_src_q <= SRC_RC;
            ctl_div_q <= DIV_RST;
        end else if (wr_en) begin
            ctl_src_q <= wr_src;
            ctl_div_q <= wr_div;
        end
    end

    assign cfg_diff = (ctl_src_q != act_src) || (ctl_div_q != act_div);

    // State register
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RAISE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (mon_fault)     state_d = ST_WAKE;
                else if (cfg_diff) state_d = ST_DROP;
            end
            ST_DROP:  if (!ack_s[act_src])    state_d = ST_WAKE;
            ST_WAKE:  if (src_ready[act_src]) state_d = ST_RAISE;
            ST_RAISE: if (ack_s[act_src])     state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Output / datapath process: requests and active selection
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            act_src <= SRC_RC;
            act_div <= DIV_RST;
            req_q   <= RC_ONEHOT;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (mon_fault) begin
                        act_src <= SRC_RC;
                        act_div <= DIV_RST;
                        req_q   <= '0;
                    end else if (cfg_diff) begin
                        req_q   <= '0;
                    end
                end
                ST_DROP: begin
                    if (!ack_s[act_src]) begin
                        act_src <= ctl_src_q;
                        act_div <= ctl_div_q;
                    end
                end
                ST_WAKE: begin
                    if (src_ready[act_src]) req_q <= NSRC'(1) << act_src;
                end
                default: ;
            endcase
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign ctl_src = ctl_src_q;
    assign ctl_div = ctl_div_q;
endmodule

// File: rtl/clksel_checker.sv
module clksel_checker
    import clksel_pkg::*;
#(
    parameter int DIV_W   = 3,
    parameter int DEF_DIV = 1
) (
    input logic             ref_clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             busy,
    input logic             fault,
    input logic [NSRC-1:0]  req,
    input logic [NSRC-1:0]  ack,
    input logic [SRC_W-1:0] act_src,
    input logic [SRC_W-1:0] ctl_src,
    input logic [DIV_W-1:0] act_div,
    input logic [DIV_W-1:0] ctl_div
);
    // R3: never request two gates at once
    p_req_onehot_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $onehot0(req));

    // R4: a switch ends only once the new gate has acknowledged
    p_done_acked_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(busy) |-> ack[act_src]);

    // R5: control register holds without a write or a timeout
    p_ctl_hold_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!wr_en && !fault) |=> ($stable(ctl_src) && $stable(ctl_div)));

    // R8: a timeout restores the default and starts a switch
    p_fallback_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        fault |=> (ctl_src == SRC_RC && ctl_div == DIV_W'(DEF_DIV) && busy));

    // R10: no timeout while a switch runs
    p_quiet_busy_r10: assert property (@(posedge ref_clk) disable iff (!rst_n)
        busy |-> !fault);

    // R6: the active selection only moves inside a switch
    p_act_hold_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!busy && !fault) |=> ($stable(act_src) && $stable(act_div)));
endmodule

bind clk_selector clksel_checker #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_chk (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .busy    (busy),
    .fault   (mon_fault),
    .req     (req_q),
    .ack     (ack_s),
    .act_src (act_src),
    .ctl_src (ctl_src),
    .act_div (act_div),
    .ctl_div (ctl_div)
);

// File: tb/tb_clk_selector.sv
`timescale 1ns/1ps
module tb_clk_selector;
    localparam int PER [4] = '{60, 220, 100, 140};
    localparam int MIN_HALF = 30;

    logic       ref_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic [3:0] src_clk;
    logic [3:0] run     = 4'hF;
    logic [3:0] ready   = 4'hF;
    logic       wr_en   = 1'b0;
    logic [1:0] wr_src  = '0;
    logic [2:0] wr_div  = '0;
    logic [15:0] tmo    = 16'd1000;
    logic       sys_clk, busy;
    logic [1:0] ctl_src;
    logic [2:0] ctl_div;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;
    int cur_s, cur_d;

    always #10 ref_clk = ~ref_clk;

    for (genvar i = 0; i < 4; i++) begin : g_osc
        logic c = 1'b0;
        always begin
            #(PER[i] / 2);
            if (run[i] || c) c = ~c;
        end
        assign src_clk[i] = c;
    end

    clk_selector dut (
        .ref_clk(ref_clk), .rst_n(rst_n), .src_clk(src_clk), .src_ready(ready),
        .wr_en(wr_en), .wr_src(wr_src), .wr_div(wr_div), .tmo_limit(tmo),
        .sys_clk(sys_clk), .busy(busy), .ctl_src(ctl_src), .ctl_div(ctl_div)
    );

    realtime t_last = 0, t_prev = 0, t_chg = 0, min_w = 1e9;
    int n_edges = 0;
    always @(posedge sys_clk) begin
        t_prev = t_last;
        t_last = $realtime;
        n_edges++;
    end
    always @(sys_clk) begin
        if ($realtime - t_chg < min_w) min_w = $realtime - t_chg;
        t_chg = $realtime;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic write_cfg(input int s, input int d);
        wr_src = 2'(s);
        wr_div = 3'(d);
        wr_en  = 1'b1;
        @(negedge ref_clk);
        wr_en  = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (busy && n < 3000) begin
            @(negedge ref_clk);
            n++;
        end
        chk(!busy, tag, int'(busy), 0);
    endtask

    task automatic measure(output int per);
        int e0 = n_edges;
        int n = 0;
        while (n_edges < e0 + 3 && n < 20000) begin
            @(negedge ref_clk);
            n++;
        end
        per = (n_edges >= e0 + 3) ? int'(t_last - t_prev) : -1;
    endtask

    task automatic do_switch(input int s, input int d);
        int per;
        bit diff = (s != cur_s) || (d != cur_d);
        min_w = 1e9;
        write_cfg(s, d);
        @(negedge ref_clk);
        chk(busy == diff, diff ? "R4 busy rises" : "R6 no switch", int'(busy), int'(diff));
        wait_idle("R4 completes");
        measure(per);
        chk(per == (PER[s] << d), (s == cur_s) ? "R11 divider-only period" : "R2 period",
            per, PER[s] << d);
        if (diff) chk(min_w >= MIN_HALF, "R3 min pulse", int'(min_w), MIN_HALF);
        cur_s = s;
        cur_d = d;
    endtask

    initial begin
        int per;
        int e0;
        cyc(5);
        chk(ctl_src == 2, "R1 reset src", ctl_src, 2);
        chk(ctl_div == 1, "R1 reset div", ctl_div, 1);
        rst_n = 1'b1;
        @(negedge ref_clk);
        chk(ctl_src == 2 && ctl_div == 1, "R1 after reset", {ctl_src, ctl_div}, {2'd2, 3'd1});
        wait_idle("R1 start");
        measure(per);
        chk(per == 200, "R1 reset period", per, 200);
        cur_s = 2;
        cur_d = 1;

        // R2 sweep over all sources and four dividers
        for (int s = 0; s < 4; s++)
            for (int d = 0; d < 4; d++)
                do_switch(s, d);

        // R6: rewrite current selection
        write_cfg(cur_s, cur_d);
        for (int k = 0; k < 5; k++) begin
            @(negedge ref_clk);
            chk(!busy, "R6 busy stays low", int'(busy), 0);
        end

        // R5: write during a running switch
        write_cfg(1, 0);
        @(negedge ref_clk);
        chk(busy, "R5 first switch busy", int'(busy), 1);
        write_cfg(0, 2);
        chk(ctl_src == 0 && ctl_div == 2, "R5 readback", {ctl_src, ctl_div}, {2'd0, 3'd2});
        wait_idle("R5 first done");
        cyc(3);
        wait_idle("R5 second done");
        measure(per);
        chk(per == 240, "R5 last write applied", per, 240);
        cur_s = 0;
        cur_d = 2;

        // R7 / R10: wait for ready longer than the timeout
        tmo = 16'd20;
        ready[1] = 1'b0;
        write_cfg(1, 0);
        cyc(100);
        e0 = n_edges;
        cyc(100);
        chk(busy, "R7 busy while not ready", int'(busy), 1);
        chk(n_edges == e0, "R7 output stopped", n_edges - e0, 0);
        chk(ctl_src == 1, "R10 no fallback while busy", ctl_src, 1);
        ready[1] = 1'b1;
        wait_idle("R7 completes");
        measure(per);
        chk(per == 220, "R7 period after ready", per, 220);

        // R9: monitor disabled
        tmo = 16'd0;
        run[1] = 1'b0;
        cyc(300);
        chk(ctl_src == 1 && ctl_div == 0, "R9 ctl unchanged", {ctl_src, ctl_div}, {2'd1, 3'd0});
        chk(!busy, "R9 no switch", int'(busy), 0);
        run[1] = 1'b1;
        measure(per);
        chk(per == 220, "R9 resumed period", per, 220);

        // R8: timeout fallback
        tmo = 16'd50;
        run[1] = 1'b0;
        cyc(80);
        chk(ctl_src == 2 && ctl_div == 1, "R8 fallback ctl", {ctl_src, ctl_div}, {2'd2, 3'd1});
        wait_idle("R8 completes");
        measure(per);
        chk(per == 200, "R8 fallback period", per, 200);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        finished = 1;
        $finish;
    end

    initial begin
        #3ms;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule